// File: doc/BRIEF.md
# I/O Write-Allocate Cache Tag Controller

This block holds the tags, valid bits and dirty bits of a small set-associative last-level cache that serves two requester classes: processor cores and DMA-capable devices. For every accepted request it decides whether the cache is hit. On a miss it decides whether a line is allocated, which way it goes into, and what traffic the memory side must carry. That traffic can be a fill, a writeback of a dirty victim, or a pass-through read or write that skips the cache.

Device writes that find their line anywhere in the set overwrite it in place. Device writes that miss may only take a way from a programmable I/O way mask. Core misses are confined to a separate core way mask, so the two classes can be kept apart. Each device port can be set to skip the cache altogether. Every request is decided in the cycle it is accepted, and the response and memory commands are presented one clock later.

Top module: `io_dca_ctrl`

## Requirements
- R1: A device write that hits any of the 11 ways (including ways outside the I/O mask) reports a hit on that way, marks the line dirty and issues no memory command.
- R2: A device write miss takes its victim only from ways whose bit is set in the I/O mask (bit n enables way n). The choice is round-robin per set: the search starts at that set's pointer, skips ways whose bit is clear, and afterwards the pointer moves to one past the chosen way, wrapping from way 10 to way 0.
- R3: After reset the I/O mask is 0x600 (ways 9 and 10), the core mask is 0x1FF (ways 0 to 8), no port bypasses the cache, all lines are invalid, every round-robin pointer is 0, and all outputs and counters are zero.
- R4: A device read that hits reports the hit and its way. A device read that misses issues a memory read and allocates nothing.
- R5: A core read miss allocates a clean line with a fill into a way from the core mask, using its own per-set round-robin pointer. With an all-zero core mask it issues a memory read instead. A core hit reports its way.
- R6: When a port's bypass bit is set, that port's writes issue a memory write and its reads issue a memory read. No hit is reported and nothing is allocated. A bypassed write that matches a resident line invalidates that line.
- R7: When the chosen victim is valid and dirty, the same response carries a writeback of the victim's line address {tag, set}.
- R8: An allocating device write covering the full line installs the line dirty without a fill. A partial write installs it dirty with a fill.
- R9: With an all-zero I/O mask, a device write miss issues a memory write and allocates nothing.
- R10: Register writes use cfg_sel 0 for the I/O mask, 1 for the core mask and 2 for the port bypass bits (bit p for port p). A request accepted in the same cycle as a register write still uses the old value. Resident lines are never moved or invalidated by a mask change.
- R11: Four counters count non-bypassed device write hits, write misses, read hits and read misses, each rising by one per event.
- R12: A device request has priority. core_grant is high only when core_valid is high and dma_valid is low, and only a granted core request is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_valid | input | 1 | Device request present |
| dma_write | input | 1 | 1 for write, 0 for read |
| dma_full_line | input | 1 | Write covers the whole line |
| dma_port | input | 1 | Device port number |
| dma_addr | input | 12 | Device line address {tag, set} |
| core_valid | input | 1 | Core read request present |
| core_addr | input | 12 | Core line address {tag, set} |
| core_grant | output | 1 | Core request accepted this cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 11 | Register write data |
| rsp_valid | output | 1 | Decision for last cycle's request |
| rsp_hit | output | 1 | Request hit in the cache |
| rsp_way | output | 4 | Hit or allocated way, else 0 |
| mem_wb_valid | output | 1 | Write back dirty victim |
| mem_wb_addr | output | 12 | Victim line address |
| mem_fill | output | 1 | Fetch line from memory into the cache |
| mem_rd | output | 1 | Pass-through read from memory |
| mem_wr | output | 1 | Pass-through write to memory |
| mem_addr | output | 12 | Request line address for fill or pass-through |
| cnt_wr_hit | output | 16 | Device write hit count |
| cnt_wr_miss | output | 16 | Device write miss count |
| cnt_rd_hit | output | 16 | Device read hit count |
| cnt_rd_miss | output | 16 | Device read miss count |

## Verification
The main test runs several patterns against one set. A core fill followed by a device write to the same line shows whether hits may land outside the I/O ways. A run of device write misses shows whether the round-robin pointer confines allocation to the mask and whether dirty victims are written back. A pair of identical read misses shows whether reads allocate. Directed steps then change the masks and the bypass bits, and include a register write in the same cycle as a request. They separate a decision made on old register values from one made on new values, and a mask change from any disturbance of resident lines.

// File: rtl/io_dca_pkg.sv
package io_dca_pkg;
    typedef enum logic [1:0] {
        SEL_IO_MASK   = 2'd0,
        SEL_CORE_MASK = 2'd1,
        SEL_BYPASS    = 2'd2
    } cfg_sel_e;
endpackage

// File: rtl/dca_tag_match.sv
module dca_tag_match #(
    parameter int WAYS = 11,
    parameter int TW   = 10,
    localparam int WIDX = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TW-1:0] tags,
    input  logic [WAYS-1:0]         valid,
    input  logic [TW-1:0]           tag,
    output logic                    hit,
    output logic [WIDX-1:0]         way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == tag);
    end

    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && match[w]) begin
                hit = 1'b1;
                way = WIDX'(w);
            end
        end
    end
endmodule

// File: rtl/dca_rr_victim.sv
module dca_rr_victim #(
    parameter int WAYS = 11,
    localparam int WIDX = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] mask,
    input  logic [WIDX-1:0] ptr,
    output logic            found,
    output logic [WIDX-1:0] way
);
    always_comb begin
        found = 1'b0;
        way   = '0;
        for (int k = 0; k < WAYS; k++) begin
            int i;
            i = int'(ptr) + k;
            if (i >= WAYS) i = i - WAYS;
            if (i >= WAYS) i = i - WAYS;
            if (!found && mask[i]) begin
                found = 1'b1;
                way   = WIDX'(i);
            end
        end
    end
endmodule

// File: rtl/io_dca_ctrl.sv
module io_dca_ctrl
    import io_dca_pkg::*;
#(
    parameter int          WAYS          = 11,
    parameter int          SETS          = 4,
    parameter int          AW            = 12,
    parameter int          NPORT         = 2,
    parameter int          CNTW          = 16,
    parameter logic [10:0] IO_MASK_RST   = 11'h600,
    parameter logic [10:0] CORE_MASK_RST = 11'h1FF,
    localparam int SW   = $clog2(SETS),
    localparam int TW   = AW - SW,
    localparam int WIDX = $clog2(WAYS),
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dma_valid,
    input  logic            dma_write,
    input  logic            dma_full_line,
    input  logic [PW-1:0]   dma_port,
    input  logic [AW-1:0]   dma_addr,
    input  logic            core_valid,
    input  logic [AW-1:0]   core_addr,
    output logic            core_grant,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [WAYS-1:0] cfg_wdata,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [WIDX-1:0] rsp_way,
    output logic            mem_wb_valid,
    output logic [AW-1:0]   mem_wb_addr,
    output logic            mem_fill,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [AW-1:0]   mem_addr,
    output logic [CNTW-1:0] cnt_wr_hit,
    output logic [CNTW-1:0] cnt_wr_miss,
    output logic [CNTW-1:0] cnt_rd_hit,
    output logic [CNTW-1:0] cnt_rd_miss
);
    localparam logic [WIDX-1:0] LAST_WAY = WIDX'(WAYS - 1);
    localparam logic [CNTW-1:0] ONE      = CNTW'(1);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TW-1:0] tag;
        logic [SETS-1:0][WAYS-1:0]         vld;
        logic [SETS-1:0][WAYS-1:0]         dty;
        logic [SETS-1:0][WIDX-1:0]         io_ptr;
        logic [SETS-1:0][WIDX-1:0]         core_ptr;
        logic [WAYS-1:0]                   io_mask;
        logic [WAYS-1:0]                   core_mask;
        logic [NPORT-1:0]                  byp;
        logic                              rsp_valid;
        logic                              rsp_hit;
        logic [WIDX-1:0]                   rsp_way;
        logic                              wb_valid;
        logic [AW-1:0]                     wb_addr;
        logic                              fill;
        logic                              prd;
        logic                              pwr;
        logic [AW-1:0]                     maddr;
        logic [CNTW-1:0]                   c_wh;
        logic [CNTW-1:0]                   c_wm;
        logic [CNTW-1:0]                   c_rh;
        logic [CNTW-1:0]                   c_rm;
    } state_t;

    state_t s_d, s_q;

    logic            req_dma, req_core;
    logic [AW-1:0]   r_addr;
    logic [SW-1:0]   r_set;
    logic [TW-1:0]   r_tag;
    logic            hit;
    logic [WIDX-1:0] hit_way;
    logic            io_found, core_found;
    logic [WIDX-1:0] io_way, core_way;
    logic            io_alloc;

    assign req_dma    = dma_valid;
    assign req_core   = core_valid && !dma_valid;
    assign core_grant = req_core;
    assign r_addr     = req_dma ? dma_addr : core_addr;
    assign r_set      = r_addr[SW-1:0];
    assign r_tag      = r_addr[AW-1:SW];

    dca_tag_match #(.WAYS(WAYS), .TW(TW)) u_match (
        .tags (s_q.tag[r_set]),
        .valid(s_q.vld[r_set]),
        .tag  (r_tag),
        .hit  (hit),
        .way  (hit_way)
    );

    dca_rr_victim #(.WAYS(WAYS)) u_io_victim (
        .mask (s_q.io_mask),
        .ptr  (s_q.io_ptr[r_set]),
        .found(io_found),
        .way  (io_way)
    );

    dca_rr_victim #(.WAYS(WAYS)) u_core_victim (
        .mask (s_q.core_mask),
        .ptr  (s_q.core_ptr[r_set]),
        .found(core_found),
        .way  (core_way)
    );

    assign io_alloc = req_dma && dma_write && !s_q.byp[dma_port] && !hit && io_found;

    always_comb begin
        logic [WIDX-1:0] v;
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        s_d.rsp_hit   = 1'b0;
        s_d.rsp_way   = '0;
        s_d.wb_valid  = 1'b0;
        s_d.wb_addr   = '0;
        s_d.fill      = 1'b0;
        s_d.prd       = 1'b0;
        s_d.pwr       = 1'b0;
        s_d.maddr     = '0;
        v             = '0;

        if (req_dma || req_core) begin
            s_d.rsp_valid = 1'b1;
            s_d.maddr     = r_addr;
        end

        if (req_dma && s_q.byp[dma_port]) begin
            if (dma_write) begin
                s_d.pwr = 1'b1;
                if (hit) s_d.vld[r_set][hit_way] = 1'b0;
            end else begin
                s_d.prd = 1'b1;
            end
        end else if (req_dma && dma_write) begin
            if (hit) begin
                s_d.rsp_hit                = 1'b1;
                s_d.rsp_way                = hit_way;
                s_d.dty[r_set][hit_way]    = 1'b1;
                s_d.c_wh                   = s_q.c_wh + ONE;
            end else begin
                s_d.c_wm = s_q.c_wm + ONE;
                if (io_found) begin
                    v                    = io_way;
                    s_d.rsp_way          = v;
                    s_d.fill             = !dma_full_line;
                    s_d.dty[r_set][v]    = 1'b1;
                    s_d.io_ptr[r_set]    = (v == LAST_WAY) ? '0 : v + 1'b1;
                end else begin
                    s_d.pwr = 1'b1;
                end
            end
        end else if (req_dma) begin
            if (hit) begin
                s_d.rsp_hit = 1'b1;
                s_d.rsp_way = hit_way;
                s_d.c_rh    = s_q.c_rh + ONE;
            end else begin
                s_d.prd  = 1'b1;
                s_d.c_rm = s_q.c_rm + ONE;
            end
        end else if (req_core) begin
            if (hit) begin
                s_d.rsp_hit = 1'b1;
                s_d.rsp_way = hit_way;
            end else if (core_found) begin
                v                   = core_way;
                s_d.rsp_way         = v;
                s_d.fill            = 1'b1;
                s_d.dty[r_set][v]   = 1'b0;
                s_d.core_ptr[r_set] = (v == LAST_WAY) ? '0 : v + 1'b1;
            end else begin
                s_d.prd = 1'b1;
            end
        end

        // install the new line and write back a dirty victim
        if (io_alloc || (req_core && !hit && core_found)) begin
            if (s_q.vld[r_set][v] && s_q.dty[r_set][v]) begin
                s_d.wb_valid = 1'b1;
                s_d.wb_addr  = {s_q.tag[r_set][v], r_set};
            end
            s_d.tag[r_set][v] = r_tag;
            s_d.vld[r_set][v] = 1'b1;
        end

        if (cfg_we) begin
            case (cfg_sel)
                SEL_IO_MASK:   s_d.io_mask   = cfg_wdata;
                SEL_CORE_MASK: s_d.core_mask = cfg_wdata;
                SEL_BYPASS:    s_d.byp       = cfg_wdata[NPORT-1:0];
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.io_mask   <= IO_MASK_RST[WAYS-1:0];
            s_q.core_mask <= CORE_MASK_RST[WAYS-1:0];
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid    = s_q.rsp_valid;
    assign rsp_hit      = s_q.rsp_hit;
    assign rsp_way      = s_q.rsp_way;
    assign mem_wb_valid = s_q.wb_valid;
    assign mem_wb_addr  = s_q.wb_addr;
    assign mem_fill     = s_q.fill;
    assign mem_rd       = s_q.prd;
    assign mem_wr       = s_q.pwr;
    assign mem_addr     = s_q.maddr;
    assign cnt_wr_hit   = s_q.c_wh;
    assign cnt_wr_miss  = s_q.c_wm;
    assign cnt_rd_hit   = s_q.c_rh;
    assign cnt_rd_miss  = s_q.c_rm;

    // R2
    io_way_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_alloc |-> s_q.io_mask[io_way]);

    // R1
    hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !(mem_fill || mem_wb_valid || mem_rd || mem_wr));

    // R7
    wb_with_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wb_valid |-> (rsp_valid && !rsp_hit && !mem_rd && !mem_wr));

    // R4
    one_mem_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_fill, mem_rd, mem_wr}) <= 1);

    // R6
    bypass_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && s_q.byp[dma_port]) |=> (!rsp_hit && (mem_rd || mem_wr)));

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> ((cnt_wr_miss - $past(cnt_wr_miss)) <= ONE));
endmodule

// File: tb/sim_io_dca_ctrl.sv
module sim_io_dca_ctrl;
    import io_dca_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_valid = 0, dma_write = 0, dma_full_line = 0;
    logic [0:0]  dma_port = '0;
    logic [11:0] dma_addr = '0;
    logic        core_valid = 0;
    logic [11:0] core_addr = '0;
    logic        core_grant;
    logic        cfg_we = 0;
    logic [1:0]  cfg_sel = '0;
    logic [10:0] cfg_wdata = '0;
    logic        rsp_valid, rsp_hit, mem_wb_valid, mem_fill, mem_rd, mem_wr;
    logic [3:0]  rsp_way;
    logic [11:0] mem_wb_addr, mem_addr;
    logic [15:0] cnt_wr_hit, cnt_wr_miss, cnt_rd_hit, cnt_rd_miss;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    io_dca_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .dma_valid(dma_valid), .dma_write(dma_write), .dma_full_line(dma_full_line),
        .dma_port(dma_port), .dma_addr(dma_addr),
        .core_valid(core_valid), .core_addr(core_addr), .core_grant(core_grant),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .mem_wb_valid(mem_wb_valid), .mem_wb_addr(mem_wb_addr),
        .mem_fill(mem_fill), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss),
        .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss)
    );

    // kind: 0 device write, 1 device read, 2 core read
    // flags: {hit, writeback, fill, pass read, pass write}
    typedef struct packed {
        logic [1:0] kind;
        logic       port;
        logic       full;
        logic [9:0] tag;
        logic [4:0] flags;
        logic [3:0] way;
        logic [9:0] wbtag;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{2'd2, 1'b0, 1'b0, 10'd1, 5'b00100, 4'd0,  10'd0},  // R5 core fill way 0
        '{2'd2, 1'b0, 1'b0, 10'd1, 5'b10000, 4'd0,  10'd0},  // R5 core hit
        '{2'd0, 1'b0, 1'b0, 10'd1, 5'b10000, 4'd0,  10'd0},  // R1 hit outside mask
        '{2'd0, 1'b0, 1'b1, 10'd2, 5'b00000, 4'd9,  10'd0},  // R8 full line, way 9
        '{2'd0, 1'b0, 1'b0, 10'd3, 5'b00100, 4'd10, 10'd0},  // R8 partial, way 10
        '{2'd0, 1'b0, 1'b1, 10'd4, 5'b01000, 4'd9,  10'd2},  // R7 wrap, dirty victim
        '{2'd1, 1'b0, 1'b0, 10'd4, 5'b10000, 4'd9,  10'd0},  // R4 read hit
        '{2'd1, 1'b0, 1'b0, 10'd2, 5'b00010, 4'd0,  10'd0},  // R4 read miss
        '{2'd1, 1'b0, 1'b0, 10'd2, 5'b00010, 4'd0,  10'd0},  // R4 no allocation
        '{2'd2, 1'b0, 1'b0, 10'd5, 5'b00100, 4'd1,  10'd0}   // R5 core pointer moved
    };

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic [1:0] kind, input logic port, input logic full,
                         input logic [9:0] tag);
        if (kind == 2'd2) begin
            core_valid = 1'b1;
            core_addr  = {tag, 2'b00};
        end else begin
            dma_valid     = 1'b1;
            dma_write     = (kind == 2'd0);
            dma_port      = port;
            dma_full_line = full;
            dma_addr      = {tag, 2'b00};
        end
    endtask

    task automatic finish_cycle();
        @(negedge clk);
        dma_valid  = 1'b0;
        core_valid = 1'b0;
        cfg_we     = 1'b0;
    endtask

    task automatic check_rsp(input string req, input vec_t v);
        chk(req, "rsp_valid", int'(rsp_valid), 1);
        chk(req, "flags", int'({rsp_hit, mem_wb_valid, mem_fill, mem_rd, mem_wr}), int'(v.flags));
        chk(req, "way", int'(rsp_way), int'(v.way));
        if (v.flags[3]) chk(req, "wb_addr", int'(mem_wb_addr), int'({v.wbtag, 2'b00}));
        if (v.flags[2] || v.flags[1] || v.flags[0])
            chk(req, "mem_addr", int'(mem_addr), int'({v.tag, 2'b00}));
    endtask

    task automatic run(input string req, input vec_t v);
        drive(v.kind, v.port, v.full, v.tag);
        finish_cycle();
        check_rsp(req, v);
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [10:0] data);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        finish_cycle();
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        chk("R3", "rsp_valid", int'(rsp_valid), 0);
        chk("R3", "mem cmds", int'({mem_wb_valid, mem_fill, mem_rd, mem_wr}), 0);
        chk("R3", "counters", int'(cnt_wr_hit) + int'(cnt_wr_miss) + int'(cnt_rd_hit) + int'(cnt_rd_miss), 0);

        for (int i = 0; i < 10; i++) run("R2", TBL[i]);

        // R6 port 1 bypassed
        cfg(SEL_BYPASS, 11'd2);
        run("R6", '{2'd0, 1'b1, 1'b1, 10'd4, 5'b00001, 4'd0, 10'd0});
        run("R6", '{2'd1, 1'b0, 1'b0, 10'd4, 5'b00010, 4'd0, 10'd0});
        run("R6", '{2'd1, 1'b1, 1'b0, 10'd3, 5'b00010, 4'd0, 10'd0});
        run("R6", '{2'd1, 1'b0, 1'b0, 10'd3, 5'b10000, 4'd10, 10'd0});

        // R9 empty I/O mask
        cfg(SEL_IO_MASK, 11'd0);
        run("R9", '{2'd0, 1'b0, 1'b1, 10'd6, 5'b00001, 4'd0, 10'd0});
        run("R9", '{2'd1, 1'b0, 1'b0, 10'd6, 5'b00010, 4'd0, 10'd0});

        // R10 register write in the same cycle as a request uses old mask
        cfg_we = 1'b1; cfg_sel = SEL_IO_MASK; cfg_wdata = 11'h00C;
        run("R10", '{2'd0, 1'b0, 1'b1, 10'd7, 5'b00001, 4'd0, 10'd0});
        run("R2",  '{2'd0, 1'b0, 1'b1, 10'd8, 5'b00000, 4'd2, 10'd0});
        run("R2",  '{2'd0, 1'b0, 1'b1, 10'd9, 5'b00000, 4'd3, 10'd0});
        run("R7",  '{2'd0, 1'b0, 1'b1, 10'd10, 5'b01000, 4'd2, 10'd8});
        // R10 resident line in way 10 survives the mask change; R1 hit outside mask
        run("R10", '{2'd0, 1'b0, 1'b0, 10'd3, 5'b10000, 4'd10, 10'd0});

        // R5 empty core mask
        cfg(SEL_CORE_MASK, 11'd0);
        run("R5", '{2'd2, 1'b0, 1'b0, 10'd11, 5'b00010, 4'd0, 10'd0});
        run("R5", '{2'd2, 1'b0, 1'b0, 10'd1, 5'b10000, 4'd0, 10'd0});

        // R12 device request wins over a simultaneous core request
        drive(2'd2, 1'b0, 1'b0, 10'd5);
        drive(2'd1, 1'b0, 1'b0, 10'd1);
        #1;
        chk("R12", "core_grant with dma", int'(core_grant), 0);
        finish_cycle();
        check_rsp("R12", '{2'd1, 1'b0, 1'b0, 10'd1, 5'b10000, 4'd0, 10'd0});
        core_valid = 1'b1;
        #1;
        chk("R12", "core_grant alone", int'(core_grant), 1);
        core_valid = 1'b0;
        @(negedge clk);

        // R11 counters
        chk("R11", "wr hits",   int'(cnt_wr_hit),  2);
        chk("R11", "wr misses", int'(cnt_wr_miss), 8);
        chk("R11", "rd hits",   int'(cnt_rd_hit),  3);
        chk("R11", "rd misses", int'(cnt_rd_miss), 4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule